// File: doc/BRIEF.md
# Shared Level-to-Pulse Interrupt Bridge

This block connects a group of level-sensitive peripheral interrupt lines to a single edge-sensitive interrupt input of a processor core. A parameter fixes which peripheral lines are routed to the core level, and a run-time mask input can silence individual lines. The combined request is the OR of every routed, unmasked line. When that request is present, the bridge raises a synchronous one-cycle pulse toward the core. It then holds off until the core shows that it has taken the interrupt, which it does by raising the in-service bit for this level.

A rising edge on the in-service bit acts as the acknowledge, and one acknowledge re-arms every line that shares the level. If any routed, unmasked line is still active at that moment, the bridge pulses again at once. This means a second source that asserted while the first one was being serviced is not lost. If no line is active, the bridge returns to idle.

The sequencer has three states. `ST_IDLE` means no pulse is outstanding. `ST_PULSE` is the single cycle in which the output is high. `ST_WAIT_ACK` means a pulse was issued and the acknowledge has not yet arrived. There are four transitions:
- arm: `ST_IDLE` to `ST_PULSE`, taken when a request is present.
- issue: `ST_PULSE` to `ST_WAIT_ACK`, always taken.
- rearm: `ST_WAIT_ACK` to `ST_PULSE`, taken on an acknowledge while a request is present.
- release: `ST_WAIT_ACK` to `ST_IDLE`, taken on an acknowledge with no request.

Top module: `irq_lvl_bridge`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequencer in `ST_IDLE`, so `core_pulse` is low in the cycle after that edge. It also clears the stored previous value of `core_inservice` to 0.
- R2: The combined request is the OR over i of `src_req[i] & ROUTE_MAP[i] & ~src_mask[i]`. A mask bit of 1 silences its line. A line whose `ROUTE_MAP` bit is 0 never affects the output.
- R3: In `ST_IDLE`, a combined request sampled at a clock edge moves the sequencer to `ST_PULSE`. `core_pulse` is then high for exactly that one cycle, and the next edge always moves the sequencer to `ST_WAIT_ACK`.
- R4: In `ST_WAIT_ACK`, no pulse is produced without an acknowledge, however many lines assert or stay asserted.
- R5: The acknowledge is a rising edge of `core_inservice`, meaning it was sampled 0 at one edge and 1 at the next. A level that is held high does not count as a new acknowledge.
- R6: An acknowledge seen in `ST_WAIT_ACK` while the combined request is present moves the sequencer straight to `ST_PULSE`, so a new pulse appears in the next cycle.
- R7: An acknowledge seen in `ST_WAIT_ACK` with no combined request moves the sequencer to `ST_IDLE`, and `core_pulse` stays low.
- R8: A rising edge of `core_inservice` that arrives while the sequencer is in `ST_PULSE` is not taken as the acknowledge. The bridge still goes to `ST_WAIT_ACK` and waits for a later rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | NUM_SRC | Level-sensitive peripheral interrupt requests |
| src_mask | input | NUM_SRC | Per-line mask; 1 silences the line |
| core_inservice | input | 1 | In-service bit of the core level; its rising edge is the acknowledge |
| core_pulse | output | 1 | One-cycle synchronous interrupt pulse to the core |

## Verification
A wrong sequencer state shows up at `core_pulse` no more than one edge after the stimulus that exposes it. A stuck `ST_PULSE` or `ST_IDLE` gives a pulse longer than one cycle or a second pulse with no acknowledge, and a stuck `ST_WAIT_ACK` loses the pulse that should follow an acknowledge. A fault in the edge store appears as a re-pulse on a held-high in-service level, or as a missed re-pulse after a real low-to-high transition. Mask and routing faults appear as a pulse from a silenced or unrouted line, or as a missing pulse, at the first edge in `ST_IDLE`.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PULSE    = 2'd1,
        ST_WAIT_ACK = 2'd2
    } irqb_state_e;

endpackage

// File: rtl/irqb_req_merge.sv
// Gates each peripheral line by its static route bit and its run-time mask,
// then reduces the survivors to one combined request.
module irqb_req_merge #(
    parameter int                   NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0]   ROUTE_MAP = '1
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_mask,
    output logic               req_any
);

    logic [NUM_SRC-1:0] gated;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        if (ROUTE_MAP[i]) begin : g_routed
            assign gated[i] = src_req[i] & ~src_mask[i];
        end else begin : g_unrouted
            logic unused_line;
            assign unused_line = src_req[i] ^ src_mask[i];
            assign gated[i]    = 1'b0;
        end
    end

    assign req_any = |gated;

endmodule

// File: rtl/irqb_ack_edge.sv
// Keeps the previous in-service sample and flags a low-to-high change.
module irqb_ack_edge (
    input  logic clk,
    input  logic rst,
    input  logic core_inservice,
    output logic ack_rise
);

    logic ins_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_prev <= 1'b0;
        end else begin
            ins_prev <= core_inservice;
        end
    end

    assign ack_rise = core_inservice & ~ins_prev;

endmodule

// File: rtl/irqb_seq.sv
// Three-state sequencer: arm, issue, rearm, release.
module irqb_seq
    import irqb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_any,
    input  logic        ack_rise,
    output irqb_state_e st_q,
    output logic        pulse
);

    irqb_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_any) begin
                    st_d = ST_PULSE;        // arm
                end
            end
            ST_PULSE: begin
                st_d = ST_WAIT_ACK;         // issue
            end
            ST_WAIT_ACK: begin
                if (ack_rise) begin
                    if (req_any) begin
                        st_d = ST_PULSE;    // rearm
                    end else begin
                        st_d = ST_IDLE;     // release
                    end
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        pulse = 1'b0;
        unique case (st_q)
            ST_PULSE:    pulse = 1'b1;
            ST_IDLE:     pulse = 1'b0;
            ST_WAIT_ACK: pulse = 1'b0;
            default:     pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_lvl_bridge.sv
module irq_lvl_bridge
    import irqb_pkg::*;
#(
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] ROUTE_MAP = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_mask,
    input  logic               core_inservice,
    output logic               core_pulse
);

    logic        req_any;
    logic        ack_rise;
    irqb_state_e st_q;

    irqb_req_merge #(
        .NUM_SRC   (NUM_SRC),
        .ROUTE_MAP (ROUTE_MAP)
    ) u_merge (
        .src_req  (src_req),
        .src_mask (src_mask),
        .req_any  (req_any)
    );

    irqb_ack_edge u_edge (
        .clk            (clk),
        .rst            (rst),
        .core_inservice (core_inservice),
        .ack_rise       (ack_rise)
    );

    irqb_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_any  (req_any),
        .ack_rise (ack_rise),
        .st_q     (st_q),
        .pulse    (core_pulse)
    );

endmodule

// File: rtl/irq_lvl_bridge_chk.sv
module irq_lvl_bridge_chk
    import irqb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        core_pulse,
    input logic        req_any,
    input logic        ack_rise,
    input irqb_state_e st_q
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !core_pulse);                                            // R1

    AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && req_any) |=> core_pulse);                           // R3

    AST_PULSE_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        core_pulse |=> (!core_pulse && st_q == ST_WAIT_ACK));                   // R8

    AST_HOLD_WITHOUT_ACK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT_ACK && !ack_rise) |=> !core_pulse);                    // R4

    AST_REARM_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT_ACK && ack_rise && req_any) |=> core_pulse);           // R6

    AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT_ACK && ack_rise && !req_any) |=> (st_q == ST_IDLE));   // R7

endmodule

bind irq_lvl_bridge irq_lvl_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_pulse (core_pulse),
    .req_any    (req_any),
    .ack_rise   (ack_rise),
    .st_q       (st_q)
);

// File: tb/irq_lvl_bridge_tb_top.sv
`timescale 1ns/1ps
module irq_lvl_bridge_tb_top;

    localparam int           NSRC = 4;
    localparam logic [3:0]   MAP  = 4'b1011;   // line 2 unrouted
    localparam int           NV   = 27;

    // {req tag[3:0], src_req[3:0], src_mask[3:0], inservice, expected pulse}
    localparam logic [13:0] VEC [NV] = '{
        {4'd2, 4'b0000, 4'b0000, 1'b0, 1'b0},   // R2 nothing active
        {4'd2, 4'b0100, 4'b0000, 1'b0, 1'b0},   // R2 unrouted line
        {4'd2, 4'b0001, 4'b0001, 1'b0, 1'b0},   // R2 masked line
        {4'd2, 4'b1011, 4'b1011, 1'b0, 1'b0},   // R2 all routed masked
        {4'd3, 4'b0001, 4'b0000, 1'b0, 1'b1},   // R3 arm
        {4'd3, 4'b0001, 4'b0000, 1'b0, 1'b0},   // R3 issue
        {4'd4, 4'b0011, 4'b0000, 1'b0, 1'b0},   // R4 new source held off
        {4'd4, 4'b0011, 4'b0000, 1'b0, 1'b0},   // R4
        {4'd6, 4'b0011, 4'b0000, 1'b1, 1'b1},   // R6 rearm
        {4'd3, 4'b0011, 4'b0000, 1'b1, 1'b0},   // R3 one cycle
        {4'd5, 4'b0011, 4'b0000, 1'b1, 1'b0},   // R5 held high
        {4'd5, 4'b0011, 4'b0000, 1'b0, 1'b0},   // R5 falls
        {4'd7, 4'b0000, 4'b0000, 1'b1, 1'b0},   // R7 release
        {4'd3, 4'b1000, 4'b0000, 1'b1, 1'b1},   // R3 arm from line 3
        {4'd3, 4'b1000, 4'b0000, 1'b1, 1'b0},   // R3
        {4'd5, 4'b1000, 4'b0000, 1'b0, 1'b0},   // R5
        {4'd7, 4'b0000, 4'b0000, 1'b1, 1'b0},   // R7
        {4'd2, 4'b0000, 4'b0000, 1'b0, 1'b0},   // R2 idle quiet
        {4'd3, 4'b0001, 4'b0000, 1'b0, 1'b1},   // R3 arm
        {4'd8, 4'b0001, 4'b0000, 1'b1, 1'b0},   // R8 rise during pulse
        {4'd8, 4'b0001, 4'b0000, 1'b1, 1'b0},   // R8 not an ack
        {4'd5, 4'b0001, 4'b0000, 1'b0, 1'b0},   // R5
        {4'd6, 4'b0001, 4'b0000, 1'b1, 1'b1},   // R6 rearm
        {4'd3, 4'b0001, 4'b0001, 1'b1, 1'b0},   // R3
        {4'd5, 4'b0001, 4'b0001, 1'b0, 1'b0},   // R5
        {4'd7, 4'b0001, 4'b0001, 1'b1, 1'b0},   // R7 masked at ack
        {4'd2, 4'b0001, 4'b0001, 1'b0, 1'b0}    // R2 stays idle
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_req = '0;
    logic [NSRC-1:0] src_mask = '0;
    logic            core_inservice = 1'b0;
    logic            core_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_lvl_bridge #(.NUM_SRC(NSRC), .ROUTE_MAP(MAP)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .src_req        (src_req),
        .src_mask       (src_mask),
        .core_inservice (core_inservice),
        .core_pulse     (core_pulse)
    );

    task automatic chk(input logic exp, input int tag, input string what);
        n_chk++;
        if (core_pulse !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: core_pulse actual=%b expected=%b", tag, what, core_pulse, exp);
        end
    endtask

    task automatic step(input logic [3:0] rq, input logic [3:0] mk, input logic ins);
        @(negedge clk);
        src_req        = rq;
        src_mask       = mk;
        core_inservice = ins;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with a routed request present
        src_req = 4'b0001;
        repeat (3) @(posedge clk);
        #1;
        chk(1'b0, 1, "held in reset");
        step(4'b0000, 4'b0000, 1'b0);
        chk(1'b0, 1, "last reset edge");
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][9:6], VEC[v][5:2], VEC[v][1]);
            chk(VEC[v][0], int'(VEC[v][13:10]), $sformatf("vector %0d", v));
        end

        // R1: reset while the pulse is high
        step(4'b0001, 4'b0000, 1'b0);
        chk(1'b1, 3, "arm before reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(1'b0, 1, "reset during pulse");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk(1'b1, 3, "arm after reset release");
        step(4'b0001, 4'b0000, 1'b0);
        chk(1'b0, 3, "issue after reset");

        // R1: reset while waiting for acknowledge returns to idle
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk(1'b0, 1, "reset during wait");
        @(negedge clk);
        rst = 1'b0;
        src_req = 4'b0000;
        @(posedge clk);
        #1;
        chk(1'b0, 1, "idle after reset, no request");
        step(4'b1000, 4'b0000, 1'b0);
        chk(1'b1, 1, "idle (not waiting) after reset in wait");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule